// File: doc/BRIEF.md
# Extended Shared-Interrupt Group Register Bank

This block holds one group bit per interrupt for an extended range of shared interrupts, packed 32 to a register. A simple word bus with separate read and write strobes, a byte offset, write data and a flag marking the access as secure reaches the bank. A 0 in a bit places the interrupt in group 0, which is the secure group when security is enabled. A 1 places it in group 1, which is non-secure group 1 when security is enabled.

Every bit is filtered before any access sees it. The filter takes into account whether the extended range is present at all, how many registers are implemented, a per-bit implemented mask, the affinity-routing enable of the interrupt's security state, and the secure/non-secure status of the access. The same filtered ("effective") bits are exported as a flat vector for prioritisation logic. A combinational lookup port returns the effective bit for a single interrupt ID.

The interrupt ID space starts at 4096. Interrupt m lives in register (m-4096)/32 at bit (m-4096) mod 32. Register n sits at byte offset 0x1000 + 4*n.

Top module: `intgrp_bank`

## Requirements
- R1: After reset every stored bit is 0: reads of any register return 0 and `group_vec` is all zeros.
- R2: Register n answers at byte offset 0x1000+4*n (word aligned only). Read data appears on `rdata` in the cycle after `rd_en` is sampled and holds until the next read. A read and a write in the same cycle return the value held before the write.
- R3: While `cfg_ext_present` is 0, every read returns 0, writes change nothing, and `group_vec` and `lk_group` are 0. Stored values persist and reappear when the input returns to 1.
- R4: Unaligned offsets, offsets outside 0x1000..0x1000+4*NREG-1, and register indices greater than `cfg_range` read as 0 and ignore writes.
- R5: A write stores `wdata` into every bit the filter permits and leaves all other bits unchanged. With `cfg_ds`=1 or `acc_secure`=1, the security filter permits every bit.
- R6: With `cfg_ds`=0, a non-secure access treats a bit whose stored value is 0 as secure: it reads 0 and cannot be written. A bit stored as 1 is readable and may be cleared by a non-secure access.
- R7: Affinity-routing gating: with `cfg_ds`=1, `cfg_are_s` governs every bit. With `cfg_ds`=0, a bit stored as 0 is governed by `cfg_are_s` and a bit stored as 1 by `cfg_are_ns`. A bit whose enable is 0 reads 0 and ignores writes.
- R8: A bit whose `impl_mask` entry is 0 reads 0, ignores writes and is 0 in `group_vec`. Bit k of `impl_mask` belongs to register k/32, bit k%32.
- R9: `lk_group` returns the effective bit of interrupt `lk_id` (register (lk_id-4096)>>5, bit (lk_id-4096)&31) combinationally. IDs below 4096 or at or above 4096+32*NREG return 0.
- R10: Bit k of `group_vec` is the effective bit of register k/32, bit k%32. It is the stored bit gated by presence, range, implemented mask and affinity-routing enable, independent of access security.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_present | input | 1 | Extended range present |
| cfg_range | input | IDX_W | Highest implemented register index |
| cfg_ds | input | 1 | Security disabled (single security state) |
| cfg_are_s | input | 1 | Affinity routing enabled, secure state |
| cfg_are_ns | input | 1 | Affinity routing enabled, non-secure state |
| impl_mask | input | 32*NREG | Per-interrupt implemented mask |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte offset |
| wdata | input | 32 | Write data |
| acc_secure | input | 1 | Access is secure |
| rdata | output | 32 | Registered read data |
| lk_id | input | ID_W | Lookup interrupt ID |
| lk_group | output | 1 | Effective group bit of `lk_id` |
| group_vec | output | 32*NREG | Effective group bits of all interrupts |

## Verification
The properties assume that the configuration inputs (`cfg_*`, `impl_mask`) change only between bus accesses, never in the same cycle as a write whose effect is being judged. The non-secure and quiet-bus properties therefore excuse any cycle where the configuration moved. They also assume that strobes are single-cycle word accesses with a defined address. The stimulus drives every input on the falling edge. It alters configuration only in idle cycles with both strobes low, and issues each access as a one-cycle pulse, so every property sees the inputs it relies on.

// File: rtl/intgrp_pkg.sv
package intgrp_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned BANK_BASE   = 32'h0000_1000;
  localparam int unsigned FIRST_ID    = 4096;
endpackage

// File: rtl/intgrp_decode.sv
module intgrp_decode
  import intgrp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IDX_W  = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BANK_BASE);

  logic [ADDR_W-1:0] rel;

  always_comb begin
    rel = addr - BASE_A;
    hit = (addr >= BASE_A) &&
          (rel[ADDR_W-1:IDX_W+2] == '0) &&
          (rel[1:0] == 2'b00);
    idx = rel[IDX_W+1:2];
  end
endmodule

// File: rtl/intgrp_cfgmask.sv
module intgrp_cfgmask
  import intgrp_pkg::*;
#(
  parameter int unsigned REG_IDX = 0,
  parameter int unsigned IDX_W   = 5
) (
  input  logic              present,
  input  logic [IDX_W-1:0]  range_max,
  input  logic              ds,
  input  logic              are_s,
  input  logic              are_ns,
  input  logic [WORD_W-1:0] impl,
  input  logic [WORD_W-1:0] stored,
  output logic [WORD_W-1:0] cfg_ok
);
  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(REG_IDX);

  logic              reg_live;
  logic [WORD_W-1:0] are_vec;

  always_comb begin
    reg_live = present && (MY_IDX <= range_max);
    if (ds) begin
      are_vec = {WORD_W{are_s}};
    end else begin
      are_vec = (stored & {WORD_W{are_ns}}) | (~stored & {WORD_W{are_s}});
    end
    cfg_ok = {WORD_W{reg_live}} & impl & are_vec;
  end
endmodule

// File: rtl/intgrp_store.sv
module intgrp_store
  import intgrp_pkg::*;
#(
  parameter int unsigned NREG  = 32,
  parameter int unsigned IDX_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [IDX_W-1:0]             widx,
  input  logic [WORD_W-1:0]            wdata,
  input  logic [WORD_W-1:0]            wmask,
  output logic [NREG-1:0][WORD_W-1:0]  q
);
  logic [NREG-1:0][WORD_W-1:0] q_nxt;
  logic [NREG-1:0]             reg_ce;

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      reg_ce[r] = we && (widx == IDX_W'(r));
      q_nxt[r]  = (q[r] & ~wmask) | (wdata & wmask);
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[r] <= '0;
      end else if (reg_ce[r]) begin
        q[r] <= q_nxt[r];
      end
    end
  end
endmodule

// File: rtl/intgrp_lookup.sv
module intgrp_lookup
  import intgrp_pkg::*;
#(
  parameter int unsigned TOTAL = 1024,
  parameter int unsigned ID_W  = 13
) (
  input  logic [ID_W-1:0]  id,
  input  logic [TOTAL-1:0] eff_vec,
  output logic             grp
);
  localparam int unsigned LK_W = $clog2(TOTAL);

  logic [31:0] id_w;
  logic [31:0] off_w;
  logic        in_rng;

  always_comb begin
    id_w   = 32'(id);
    off_w  = id_w - FIRST_ID;
    in_rng = (id_w >= FIRST_ID) && (off_w[31:LK_W] == '0);
    grp    = in_rng && eff_vec[off_w[LK_W-1:0]];
  end
endmodule

// File: rtl/intgrp_bank.sv
module intgrp_bank
  import intgrp_pkg::*;
#(
  parameter int unsigned NREG   = 32,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned ID_W   = 13,
  localparam int unsigned IDX_W = $clog2(NREG),
  localparam int unsigned TOTAL = NREG * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_ext_present,
  input  logic [IDX_W-1:0]   cfg_range,
  input  logic               cfg_ds,
  input  logic               cfg_are_s,
  input  logic               cfg_are_ns,
  input  logic [TOTAL-1:0]   impl_mask,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               acc_secure,
  output logic [WORD_W-1:0]  rdata,
  input  logic [ID_W-1:0]    lk_id,
  output logic               lk_group,
  output logic [TOTAL-1:0]   group_vec
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync[1];

  // address decode
  logic             hit;
  logic [IDX_W-1:0] idx;

  intgrp_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr (addr),
    .hit  (hit),
    .idx  (idx)
  );

  // storage
  logic [NREG-1:0][WORD_W-1:0] stored;
  logic [NREG-1:0][WORD_W-1:0] cfg_ok;
  logic [WORD_W-1:0]           acc_ok;
  logic                        we;

  // per-register configuration masks
  for (genvar r = 0; r < NREG; r++) begin : g_mask
    intgrp_cfgmask #(.REG_IDX(r), .IDX_W(IDX_W)) u_mask (
      .present   (cfg_ext_present),
      .range_max (cfg_range),
      .ds        (cfg_ds),
      .are_s     (cfg_are_s),
      .are_ns    (cfg_are_ns),
      .impl      (impl_mask[r*WORD_W +: WORD_W]),
      .stored    (stored[r]),
      .cfg_ok    (cfg_ok[r])
    );
    assign group_vec[r*WORD_W +: WORD_W] = stored[r] & cfg_ok[r];
  end

  // access filter: secure bits (stored 0) hidden from non-secure accesses
  always_comb begin
    if (cfg_ds || acc_secure) begin
      acc_ok = cfg_ok[idx];
    end else begin
      acc_ok = cfg_ok[idx] & stored[idx];
    end
    we = wr_en && hit;
  end

  intgrp_store #(.NREG(NREG), .IDX_W(IDX_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n_int),
    .we    (we),
    .widx  (idx),
    .wdata (wdata),
    .wmask (acc_ok),
    .q     (stored)
  );

  // registered read data
  logic [WORD_W-1:0] rdata_q;
  logic [WORD_W-1:0] rdata_nxt;

  always_comb begin
    rdata_nxt = hit ? (stored[idx] & acc_ok) : '0;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_nxt;
    end
  end
  assign rdata = rdata_q;

  intgrp_lookup #(.TOTAL(TOTAL), .ID_W(ID_W)) u_lk (
    .id      (lk_id),
    .eff_vec (group_vec),
    .grp     (lk_group)
  );
endmodule

// File: rtl/intgrp_bank_chk.sv
module intgrp_bank_chk #(
  parameter int unsigned NREG   = 32,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned ID_W   = 13,
  localparam int unsigned IDX_W = $clog2(NREG),
  localparam int unsigned TOTAL = NREG * 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_ext_present,
  input logic [IDX_W-1:0]  cfg_range,
  input logic              cfg_ds,
  input logic              cfg_are_s,
  input logic              cfg_are_ns,
  input logic [TOTAL-1:0]  impl_mask,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              acc_secure,
  input logic [31:0]       rdata,
  input logic [ID_W-1:0]   lk_id,
  input logic              lk_group,
  input logic [TOTAL-1:0]  group_vec
);
  localparam int unsigned WIN_LO = 32'h1000;
  localparam int unsigned WIN_HI = 32'h1000 + NREG * 4;

  logic [31:0] addr_w;
  logic [31:0] id_w;
  logic        in_win;
  logic        dead_reg;
  logic        id_outside;

  always_comb begin
    addr_w     = 32'(addr);
    id_w       = 32'(lk_id);
    in_win     = (addr_w >= WIN_LO) && (addr_w < WIN_HI) && (addr[1:0] == 2'b00);
    dead_reg   = addr[IDX_W+1:2] > cfg_range;
    id_outside = (id_w < 32'd4096) || (id_w >= 32'd4096 + TOTAL);
  end

  assert_absent_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !cfg_ext_present) |=> (rdata == '0));

  assert_absent_vec_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ext_present |-> (group_vec == '0) && !lk_group);

  assert_miss_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (!in_win || dead_reg)) |=> (rdata == '0));

  assert_ns_cannot_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cfg_ds && !acc_secure) |=>
      (((group_vec & ~$past(group_vec)) == '0) ||
       !$stable(cfg_ext_present) || !$stable(cfg_range) || !$stable(cfg_ds) ||
       !$stable(cfg_are_s) || !$stable(cfg_are_ns) || !$stable(impl_mask)));

  assert_quiet_bus_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=>
      ($stable(group_vec) ||
       !$stable(cfg_ext_present) || !$stable(cfg_range) || !$stable(cfg_ds) ||
       !$stable(cfg_are_s) || !$stable(cfg_are_ns) || !$stable(impl_mask)));

  assert_unimpl_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((group_vec & ~impl_mask) == '0));

  assert_lookup_outside_R9: assert property (@(posedge clk) disable iff (!rst_n)
    id_outside |-> !lk_group);

  assert_rdata_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind intgrp_bank intgrp_bank_chk #(.NREG(NREG), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_ext_present (cfg_ext_present),
  .cfg_range       (cfg_range),
  .cfg_ds          (cfg_ds),
  .cfg_are_s       (cfg_are_s),
  .cfg_are_ns      (cfg_are_ns),
  .impl_mask       (impl_mask),
  .rd_en           (rd_en),
  .wr_en           (wr_en),
  .addr            (addr),
  .acc_secure      (acc_secure),
  .rdata           (rdata),
  .lk_id           (lk_id),
  .lk_group        (lk_group),
  .group_vec       (group_vec)
);

// File: tb/tb_intgrp_bank.sv
`timescale 1ns/1ps
module tb_intgrp_bank;
  localparam int NREG  = 32;
  localparam int IDX_W = 5;
  localparam int TOTAL = NREG * 32;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_ext_present, cfg_ds, cfg_are_s, cfg_are_ns;
  logic [IDX_W-1:0] cfg_range;
  logic [TOTAL-1:0] impl_mask;
  logic             rd_en, wr_en, acc_secure;
  logic [15:0]      addr;
  logic [31:0]      wdata, rdata;
  logic [12:0]      lk_id;
  logic             lk_group;
  logic [TOTAL-1:0] group_vec;

  always #2.5 clk = ~clk;

  intgrp_bank dut (
    .clk(clk), .rst_n(rst_n), .cfg_ext_present(cfg_ext_present),
    .cfg_range(cfg_range), .cfg_ds(cfg_ds), .cfg_are_s(cfg_are_s),
    .cfg_are_ns(cfg_are_ns), .impl_mask(impl_mask), .rd_en(rd_en),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .acc_secure(acc_secure),
    .rdata(rdata), .lk_id(lk_id), .lk_group(lk_group), .group_vec(group_vec)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sb_q[$];

  logic [31:0] mdl [NREG];

  // ---- reference model from the requirements ----
  function automatic logic bit_ok(int idx, int b, logic sec);
    logic st, are;
    st  = mdl[idx][b];
    are = cfg_ds ? cfg_are_s : (st ? cfg_are_ns : cfg_are_s);
    return cfg_ext_present && (idx <= int'(cfg_range)) && impl_mask[idx*32+b]
           && are && (cfg_ds || sec || st);
  endfunction

  function automatic logic [31:0] okmask(int idx, logic sec);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = bit_ok(idx, b, sec);
    return m;
  endfunction

  function automatic logic eff(int k);
    return mdl[k/32][k%32] && bit_ok(k/32, k%32, 1'b1);
  endfunction

  function automatic logic a_hit(logic [15:0] a);
    return (a >= 16'h1000) && (a < 16'h1000 + NREG*4) && (a[1:0] == 2'b00);
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---- driver ----
  task automatic access(logic do_rd, logic do_wr, logic [15:0] a,
                        logic [31:0] d, logic sec, string tag);
    int idx;
    exp_t e;
    logic [31:0] m;
    idx = int'(a[6:2]);
    @(negedge clk);
    if (do_rd) begin
      e.exp = a_hit(a) ? (mdl[idx] & okmask(idx, sec)) : 32'h0;
      e.tag = tag;
      sb_q.push_back(e);
    end
    if (do_wr && a_hit(a)) begin
      m = okmask(idx, sec);
      mdl[idx] = (mdl[idx] & ~m) | (d & m);
    end
    rd_en = do_rd; wr_en = do_wr; addr = a; wdata = d; acc_secure = sec;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(int n, logic [31:0] d, logic sec);
    access(1'b0, 1'b1, 16'h1000 + 16'(4*n), d, sec, "");
  endtask

  task automatic rd(int n, logic sec, string tag);
    access(1'b1, 1'b0, 16'h1000 + 16'(4*n), 32'h0, sec, tag);
  endtask

  task automatic check_lookup(int id, string tag);
    logic exp;
    int off;
    @(negedge clk);
    lk_id = 13'(id);
    #1;
    off = id - 4096;
    exp = (off >= 0 && off < TOTAL) ? eff(off) : 1'b0;
    check({31'h0, lk_group}, {31'h0, exp}, tag);
  endtask

  task automatic check_vec(string tag);
    logic [TOTAL-1:0] exp;
    @(negedge clk);
    for (int k = 0; k < TOTAL; k++) exp[k] = eff(k);
    checks++;
    if (group_vec !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, group_vec, exp);
    end
  endtask

  // ---- monitor ----
  logic pend_q = 1'b0;
  always @(posedge clk) pend_q <= rd_en && rst_n;

  always @(negedge clk) begin
    if (pend_q) begin
      if (sb_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected read result actual=%h expected=none", rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(rdata, e.exp, e.tag);
      end
    end
  end

  // ---- watchdog ----
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // ---- stimulus ----
  initial begin
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    acc_secure = 1'b0; lk_id = '0;
    cfg_ext_present = 1'b1; cfg_range = 5'd3; cfg_ds = 1'b1;
    cfg_are_s = 1'b1; cfg_are_ns = 1'b1;
    impl_mask = '1;
    impl_mask[63:48] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(0, 1'b1, "R1 reset reg0");
    rd(2, 1'b1, "R1 reset reg2");
    check_vec("R1 reset group_vec");

    // R5 / R2 secure write and readback
    wr(0, 32'hA5A5_5A5A, 1'b1);
    rd(0, 1'b1, "R5 reg0 readback");
    wr(3, 32'h1234_8001, 1'b1);
    rd(3, 1'b1, "R2 reg3 offset 0x100C");
    // R8 implemented mask clips reg1 upper half
    wr(1, 32'hFFFF_FFFF, 1'b1);
    rd(1, 1'b1, "R8 reg1 upper bits unimplemented");
    check_vec("R10 group_vec after writes");

    // R2 read and write together return old value
    access(1'b1, 1'b1, 16'h1000, 32'h0000_FFFF, 1'b1, "R2 read-before-write");
    rd(0, 1'b1, "R2 value after combined access");

    // R4 beyond range, unaligned, outside window
    wr(4, 32'hDEAD_BEEF, 1'b1);
    rd(4, 1'b1, "R4 reg4 beyond range");
    @(negedge clk); cfg_range = 5'd7;
    rd(4, 1'b1, "R4 reg4 write was ignored");
    access(1'b0, 1'b1, 16'h1002, 32'hFFFF_FFFF, 1'b1, "");
    rd(0, 1'b1, "R4 unaligned write ignored");
    access(1'b1, 1'b0, 16'h0FFC, 32'h0, 1'b1, "R4 below window");
    access(1'b1, 1'b0, 16'h1080, 32'h0, 1'b1, "R4 above window");
    access(1'b1, 1'b0, 16'h1001, 32'h0, 1'b1, "R4 unaligned read");

    // R9 lookup
    check_lookup(4096 + 3*32 + 0,  "R9 lookup reg3 bit0");
    check_lookup(4096 + 3*32 + 1,  "R9 lookup reg3 bit1");
    check_lookup(4096 + 0*32 + 15, "R9 lookup reg0 bit15");
    check_lookup(4095,             "R9 lookup below range");
    check_lookup(4096 + TOTAL,     "R9 lookup above range");

    // R7 affinity routing off with security disabled
    @(negedge clk); cfg_are_s = 1'b0;
    rd(0, 1'b1, "R7 are off reads zero");
    wr(0, 32'h0, 1'b1);
    check_lookup(4096 + 3, "R7 lookup with are off");
    @(negedge clk); cfg_are_s = 1'b1;
    rd(0, 1'b1, "R7 are restored value kept");

    // R6 security enabled
    @(negedge clk); cfg_ds = 1'b0;
    rd(3, 1'b0, "R6 ns read sees only group1 bits");
    wr(3, 32'hFFFF_FFFE, 1'b0);
    rd(3, 1'b1, "R6 ns cannot set secure bits, can clear");
    wr(3, 32'h0000_00F0, 1'b1);
    rd(3, 1'b1, "R5 secure write with ds=0");
    rd(3, 1'b0, "R6 ns read after secure write");
    // R7 ns routing off hides group1 bits
    @(negedge clk); cfg_are_ns = 1'b0;
    rd(3, 1'b1, "R7 are_ns off hides group1");
    check_vec("R10 group_vec with are_ns off");
    @(negedge clk); cfg_are_ns = 1'b1;

    // R3 extended range absent
    @(negedge clk); cfg_ext_present = 1'b0;
    rd(0, 1'b1, "R3 absent read");
    wr(0, 32'h0, 1'b1);
    check_vec("R3 absent group_vec");
    check_lookup(4096 + 1, "R3 absent lookup");
    @(negedge clk); cfg_ext_present = 1'b1;
    rd(0, 1'b1, "R3 value persists");
    check_vec("R10 final group_vec");

    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2 missing read results actual=%0d expected=0", sb_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule